// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers up to 32 interrupt sources in a status register. It always shows the index of the most urgent pending source as a 5-bit vector. Software reads the vector register, services that source, and writes the same vector back to retire it. An all-clear flag in the vector word tells software when nothing is left to service.

Interrupts are raised in two ways. Software writes a mask to the pending-set register, or the serial link reports an error event that sets a bit chosen in the control register. A routing bit in the control register decides where raised interrupts go. They can go to a level-sensitive local interrupt line. They can also go to a one-cycle request that asks the link to carry an interrupt packet; that request holds the mask of bits that were newly raised. The encoding of the packet is handled elsewhere.

Register offsets on the 8-bit address port: control at 00h, vector at 04h, status at 08h and pending-set at 14h. The pending-set offset is the value software places in the link's interrupt pointer.

Top module: `ivc_top`

## Requirements
- R1: After reset, status reads 0, control reads 0, the vector register reads 8000_0000h, `irq_out` is 0 and `pkt_valid` is 0.
- R2: A write to offset 14h ORs the low 32 data bits into the status register (bit n of data raises source n). Reading offset 14h returns the status register.
- R3: Reading offset 04h returns, in bits 4:0, the lowest-numbered set status bit. Bit 0 has the highest priority and bit 31 the lowest. Bits 30:5 read 0.
- R4: Bit 31 of the vector register reads 1 exactly when no status bit is set. Bits 4:0 then read 0.
- R5: A write to offset 04h clears the status bit whose index is in data bits 4:0. All other bits are unchanged, and clearing a bit that is already clear has no effect.
- R6: A write to offset 08h clears every status bit whose data bit is 1 and leaves the others unchanged.
- R7: If a bit is raised and cleared in the same cycle, it ends up set.
- R8: When control bit 1 (error enable) is 1, a cycle with `err_evt` high sets the status bit indexed by control bits 12:8. When control bit 1 is 0, the event has no effect.
- R9: When control bit 0 (local routing) is 1, `irq_out` is 1 in every cycle where any status bit is set, and 0 otherwise. No packet request is made.
- R10: When control bit 0 is 0, `irq_out` stays 0. Any cycle that raises status bits that were clear gives a `pkt_valid` pulse one cycle long in the next cycle, and `pkt_bits` carries exactly those newly raised bits. Raising only bits that are already set gives no pulse.
- R11: Offset 00h is read/write and holds local routing in bit 0, error enable in bit 1 and the error vector in bits 12:8. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| err_evt | input | 1 | Serial bus error event, one cycle per event |
| irq_out | output | 1 | Local interrupt line, level |
| pkt_valid | output | 1 | One-cycle request to send an interrupt packet |
| pkt_bits | output | 32 | Newly raised status bits that go with `pkt_valid` |

## Verification
The assertions assume a single register write per cycle. They also assume that the address port holds a defined value whenever `reg_we` is high, and that `err_evt` is never unknown after reset. The bench changes inputs only on falling clock edges. It holds `reg_we` and `err_evt` low during reset. It makes the raise-versus-clear collision only by pulsing `err_evt` in the same cycle as a vector write, because the register port cannot carry two writes at once.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int IRQ_N   = 32;
    localparam int VEC_W   = $clog2(IRQ_N);
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_VEC  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PSET = 8'h14;

    localparam int NONE_BIT      = DATA_W - 1;
    localparam int CTL_ROUTE_BIT = 0;
    localparam int CTL_ERREN_BIT = 1;
    localparam int CTL_EVEC_LSB  = 8;

    typedef struct packed {
        logic [VEC_W-1:0] err_vec;
        logic             err_en;
        logic             route_local;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_ROUTE_BIT] = c.route_local;
        w[CTL_ERREN_BIT] = c.err_en;
        w[CTL_EVEC_LSB +: VEC_W] = c.err_vec;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.route_local = w[CTL_ROUTE_BIT];
        c.err_en      = w[CTL_ERREN_BIT];
        c.err_vec     = w[CTL_EVEC_LSB +: VEC_W];
        return c;
    endfunction

    function automatic logic [IRQ_N-1:0] vec_mask(logic [VEC_W-1:0] v);
        logic [IRQ_N-1:0] m;
        m = '0;
        m[v] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    logic [N-1:0] status_q;

    // raise dominates retire on the same bit
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_i) | set_i;
    end

    assign status_o = status_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 32,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] bits_i,
    output logic [W-1:0] vec_o,
    output logic         none_o
);
    // scan from lowest priority up so the lowest index overrides
    always_comb begin
        vec_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits_i[i]) vec_o = W'(i);
        end
    end

    assign none_o = ~|bits_i;
endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         route_local_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] status_i,
    output logic         irq_o,
    output logic         pkt_valid_o,
    output logic [N-1:0] pkt_bits_o
);
    logic [N-1:0] fresh;
    logic         pkt_v_q;
    logic [N-1:0] pkt_b_q;

    assign fresh = set_i & ~status_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_v_q <= 1'b0;
            pkt_b_q <= '0;
        end else begin
            pkt_v_q <= ~route_local_i & (|fresh);
            pkt_b_q <= route_local_i ? '0 : fresh;
        end
    end

    assign irq_o       = route_local_i & (|status_i);
    assign pkt_valid_o = pkt_v_q;
    assign pkt_bits_o  = pkt_b_q;
endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int NUM_IRQ = ivc_pkg::IRQ_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              err_evt,
    output logic              irq_out,
    output logic              pkt_valid,
    output logic [DATA_W-1:0] pkt_bits
);
    localparam int VW = $clog2(NUM_IRQ);

    ctrl_t              ctrl_q;
    logic [NUM_IRQ-1:0] status_q;
    logic [NUM_IRQ-1:0] set_w;
    logic [NUM_IRQ-1:0] clr_w;
    logic [VW-1:0]      vec_w;
    logic               none_w;
    logic [NUM_IRQ-1:0] pkt_b_w;

    logic wr_ctrl, wr_vec, wr_stat, wr_pset;
    assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
    assign wr_vec  = reg_we && (reg_addr == OFS_VEC);
    assign wr_stat = reg_we && (reg_addr == OFS_STAT);
    assign wr_pset = reg_we && (reg_addr == OFS_PSET);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_unpack(reg_wdata);
    end

    always_comb begin
        set_w = '0;
        if (wr_pset) set_w = reg_wdata[NUM_IRQ-1:0];
        if (err_evt && ctrl_q.err_en)
            set_w = set_w | NUM_IRQ'(vec_mask(ctrl_q.err_vec));
    end

    always_comb begin
        clr_w = '0;
        if (wr_stat) clr_w = reg_wdata[NUM_IRQ-1:0];
        if (wr_vec)  clr_w = NUM_IRQ'(vec_mask(reg_wdata[VEC_W-1:0]));
    end

    irq_status_reg #(.N(NUM_IRQ)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_w),
        .clr_i   (clr_w),
        .status_o(status_q)
    );

    irq_prio_enc #(.N(NUM_IRQ), .W(VW)) u_enc (
        .bits_i(status_q),
        .vec_o (vec_w),
        .none_o(none_w)
    );

    irq_route #(.N(NUM_IRQ)) u_route (
        .clk          (clk),
        .rst          (rst),
        .route_local_i(ctrl_q.route_local),
        .set_i        (set_w),
        .status_i     (status_q),
        .irq_o        (irq_out),
        .pkt_valid_o  (pkt_valid),
        .pkt_bits_o   (pkt_b_w)
    );

    always_comb begin
        pkt_bits = '0;
        pkt_bits[NUM_IRQ-1:0] = pkt_b_w;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: reg_rdata = ctrl_pack(ctrl_q);
            OFS_VEC: begin
                reg_rdata[NONE_BIT] = none_w;
                reg_rdata[VW-1:0]   = vec_w;
            end
            OFS_STAT, OFS_PSET: reg_rdata[NUM_IRQ-1:0] = status_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
    parameter int N = 32,
    parameter int W = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_we,
    input logic [7:0]   reg_addr,
    input logic [31:0]  reg_wdata,
    input logic         err_evt,
    input logic         err_en,
    input logic [W-1:0] err_vec,
    input logic         route_local,
    input logic [N-1:0] status,
    input logic [W-1:0] vec,
    input logic         none,
    input logic         irq_out,
    input logic         pkt_valid,
    input logic [31:0]  pkt_bits
);
    AST_VEC_IS_SET: assert property (@(posedge clk) disable iff (rst)
        !none |-> status[vec]); // R3

    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (rst)
        !none |-> ((status & ((N'(1) << vec) - N'(1))) == '0)); // R3

    AST_NONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        none == (status == '0)); // R4

    AST_PSET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 8'h14) |=>
        ((status & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0]))); // R2

    AST_ERR_WINS: assert property (@(posedge clk) disable iff (rst)
        (err_evt && err_en) |=> status[$past(err_vec)]); // R7

    AST_IRQ_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (route_local && status != '0) |-> irq_out); // R9

    AST_IRQ_REMOTE_LOW: assert property (@(posedge clk) disable iff (rst)
        !route_local |-> !irq_out); // R10

    AST_PKT_HELD: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_bits != '0 &&
                       (status & pkt_bits[N-1:0]) == pkt_bits[N-1:0])); // R10

    AST_PKT_NEW: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (($past(status) & pkt_bits[N-1:0]) == '0)); // R10
endmodule

bind ivc_top ivc_checker #(.N(NUM_IRQ), .W(VW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .err_evt    (err_evt),
    .err_en     (ctrl_q.err_en),
    .err_vec    (ctrl_q.err_vec[VW-1:0]),
    .route_local(ctrl_q.route_local),
    .status     (status_q),
    .vec        (vec_w),
    .none       (none_w),
    .irq_out    (irq_out),
    .pkt_valid  (pkt_valid),
    .pkt_bits   (pkt_bits)
);

// File: tb/tb_ivc_top.sv
module tb_ivc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_evt = 1'b0;
    logic        irq_out;
    logic        pkt_valid;
    logic [31:0] pkt_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ivc_top dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_evt(err_evt),
        .irq_out(irq_out), .pkt_valid(pkt_valid), .pkt_bits(pkt_bits)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // write with optional error pulse; returns after the edge, outputs settled
    task automatic wr(logic [7:0] a, logic [31:0] d, logic err = 1'b0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; err_evt = err;
        @(posedge clk); #1;
        reg_we = 1'b0; err_evt = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h04, d); check("R1 vec", d, 32'h8000_0000);
        rd(8'h08, d); check("R1 stat", d, 0);
        rd(8'h00, d); check("R1 ctrl", d, 0);
        check("R1 irq", {31'b0, irq_out}, 0);
        check("R1 pkt", {31'b0, pkt_valid}, 0);
    endtask

    task automatic t_remote();
        logic [31:0] d;
        wr(8'h14, 32'h0000_0500);
        check("R10 pulse", {31'b0, pkt_valid}, 1);
        check("R10 bits", pkt_bits, 32'h0000_0500);
        check("R10 irq low", {31'b0, irq_out}, 0);
        @(posedge clk); #1;
        check("R10 one cycle", {31'b0, pkt_valid}, 0);
        rd(8'h08, d); check("R2 stat", d, 32'h0000_0500);
        rd(8'h14, d); check("R2 pset read", d, 32'h0000_0500);
        rd(8'h04, d); check("R3 vec", d, 8);
        wr(8'h14, 32'h0000_0700);
        check("R10 new only", pkt_bits, 32'h0000_0200);
        wr(8'h14, 32'h0000_0100);
        check("R10 no pulse", {31'b0, pkt_valid}, 0);
    endtask

    task automatic t_vec_clear();
        logic [31:0] d;
        wr(8'h04, 32'd8);
        rd(8'h08, d); check("R5 clr", d, 32'h0000_0600);
        rd(8'h04, d); check("R3 next", d, 9);
        wr(8'h04, 32'd31);
        rd(8'h08, d); check("R5 clear-clear", d, 32'h0000_0600);
        wr(8'h04, 32'd9);
        wr(8'h04, 32'd10);
        rd(8'h04, d); check("R4 none", d, 32'h8000_0000);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(8'h14, 32'h8000_0003);
        rd(8'h04, d); check("R3 bit0", d, 0);
        wr(8'h08, 32'h0000_0001);
        rd(8'h08, d); check("R6 w1c", d, 32'h8000_0002);
        rd(8'h04, d); check("R3 bit1", d, 1);
        wr(8'h08, 32'h0000_0002);
        rd(8'h04, d); check("R3 bit31", d, 31);
        wr(8'h04, 32'd31);
        rd(8'h04, d); check("R4 empty", d, 32'h8000_0000);
    endtask

    task automatic t_local();
        logic [31:0] d;
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, d); check("R11 ctrl", d, 1);
        check("R9 idle", {31'b0, irq_out}, 0);
        wr(8'h14, 32'h0000_0010);
        check("R9 irq", {31'b0, irq_out}, 1);
        check("R9 no pkt", {31'b0, pkt_valid}, 0);
        wr(8'h04, 32'd4);
        check("R9 drop", {31'b0, irq_out}, 0);
    endtask

    task automatic t_err();
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_ED03);
        rd(8'h00, d); check("R11 fields", d, 32'h0000_0D03);
        @(negedge clk); err_evt = 1'b1; @(posedge clk); #1; err_evt = 1'b0;
        rd(8'h08, d); check("R8 err set", d, 32'h0000_2000);
        check("R9 err irq", {31'b0, irq_out}, 1);
        wr(8'h00, 32'h0000_1401);
        @(negedge clk); err_evt = 1'b1; @(posedge clk); #1; err_evt = 1'b0;
        rd(8'h08, d); check("R8 ignored", d, 32'h0000_2000);
        wr(8'h00, 32'h0000_0D03);
        wr(8'h04, 32'd13, 1'b1);
        rd(8'h08, d); check("R7 set wins", d, 32'h0000_2000);
        wr(8'h04, 32'd13);
        rd(8'h08, d); check("R5 after", d, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; t_reset();
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_remote();
        t_vec_clear();
        t_w1c();
        t_local();
        t_err();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule